// File: doc/BRIEF.md
# Parallel Flash Ready-Status Poller

This block waits for a byte-wide parallel NOR flash device to finish an internal program or erase operation. After a start pulse it reads the device over a simple read bus (address, read request, read data, data valid) again and again. It stops when the status bits show the device is idle. It then pulses `done`, or `timeout` when the iteration cap is reached first.

There are three ways to poll. Toggle polling compares the busy-toggle bit (bit 6) of each read with the read before it. Slow toggle polling does the same, but waits a programmable time before each new read and always reads the device base address. That wait is needed by devices that are slow to erase. Data polling compares bit 7 of each read with bit 7 of an expected data byte. A warning flag reports a poll that needed an unusually large number of iterations.

The command issue logic and the flash device itself sit outside this block.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `long_warn` and `rd_req` are all 0.
- R2: A `start` pulse while idle latches `mode`, `poll_addr` and `expect_data`, raises `busy` and clears `long_warn`. A `start` while `busy` is 1 has no effect on the running poll (same read address, same outcome).
- R3: Each read raises `rd_req` and holds it, with `rd_addr` stable, until the cycle in which `rd_valid` is 1. One byte is taken per handshake.
- R4: Mode 2'b00 (toggle) and mode 2'b01 (slow toggle) first take one reference read. Each later read is then compared with the previous read under mask 0x40. The poll completes when the two masked values are equal.
- R5: Mode 2'b10 and mode 2'b11 (data) compare each read masked with 0x80 against `expect_data` masked with 0x80. The poll completes on equality. No reference read is taken.
- R6: The iteration count is the number of compare reads in a poll. If the MAX_ITER-th compare read does not complete the poll, the poll ends with `timeout` and no `done`. A toggle poll therefore takes count+1 reads and a data poll takes count reads.
- R7: When a poll ends, `long_warn` is set if the final iteration count is greater than WARN_ITER. It holds that value until the next accepted `start`.
- R8: In slow toggle mode, every read goes to address DEV_BASE. Before each compare read, `rd_req` stays low for at least CLK_KHZ*SLOW_WAIT_US/1000 cycles. In the other modes, reads go to the latched `poll_addr` and only a couple of cycles separate reads.
- R9: `done` and `timeout` are single-cycle pulses that never occur together. `busy` is 0 in the cycle of either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll (accepted only while idle) |
| mode | input | 2 | 00 toggle, 01 slow toggle, 1x data |
| poll_addr | input | ADDR_W | Address read in toggle and data modes |
| expect_data | input | 8 | Byte whose bit 7 marks completion in data mode |
| rd_addr | output | ADDR_W | Read bus address |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_data | input | 8 | Read data from the device |
| rd_valid | input | 1 | Read data valid, ends the handshake |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse: device ready |
| timeout | output | 1 | One-cycle pulse: iteration cap reached |
| long_warn | output | 1 | Last poll needed more than WARN_ITER iterations |

## Verification
The hardest situation to reach is the exact edge of the iteration cap and the warning threshold. In that situation the device must stay busy for precisely MAX_ITER-1, MAX_ITER, WARN_ITER-1 or WARN_ITER status changes. The bench runs a device model that toggles bit 6, or holds bit 7 inverted, for a chosen number of reads B, with random read latency, and is built with a small cap and threshold. Directed polls set B to each side of both limits. Random polls cover all modes, and a start pulse is injected mid-poll.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    PM_TOGGLE      = 2'b00,
    PM_TOGGLE_SLOW = 2'b01,
    PM_DATA        = 2'b10,
    PM_DATA_ALT    = 2'b11
  } poll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF_ISSUE,
    ST_REF_WAIT,
    ST_DELAY,
    ST_CMP_ISSUE,
    ST_CMP_WAIT
  } poll_state_e;

  localparam logic [7:0] TOGGLE_MASK = 8'h40;
  localparam logic [7:0] DATA_MASK   = 8'h80;

  function automatic logic is_toggle(input poll_mode_e m);
    return (m == PM_TOGGLE) || (m == PM_TOGGLE_SLOW);
  endfunction

endpackage

// File: rtl/poll_read_port.sv
module poll_read_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic [DATA_W-1:0] got_data,
  output logic              got
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      got_data <= '0;
      got      <= 1'b0;
    end else begin
      got <= 1'b0;
      if (!rd_req && go) begin
        rd_req  <= 1'b1;
        rd_addr <= go_addr;
      end else if (rd_req && rd_valid) begin
        rd_req   <= 1'b0;
        got_data <= rd_data;
        got      <= 1'b1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R3

  AST_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
    got |-> !rd_req); // R3

endmodule

// File: rtl/poll_wait_timer.sv
module poll_wait_timer #(
  parameter int WAIT_CYC = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic fin
);

  generate
    if (WAIT_CYC == 0) begin : g_nowait
      always_ff @(posedge clk) begin
        if (rst) fin <= 1'b0;
        else     fin <= arm;
      end
    end else begin : g_wait
      localparam int TW = $clog2(WAIT_CYC + 1);
      logic [TW-1:0] left_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          left_q <= '0;
          fin    <= 1'b0;
        end else begin
          fin <= 1'b0;
          if (arm) begin
            left_q <= TW'(WAIT_CYC);
          end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            fin    <= (left_q == TW'(1));
          end
        end
      end

      AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        left_q <= TW'(WAIT_CYC)); // R8
    end
  endgenerate

endmodule

// File: rtl/poll_iter_counter.sv
module poll_iter_counter #(
  parameter int MAX_ITER  = 32'h0FFFFFFF,
  parameter int WARN_ITER = 32'h00100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last,
  output logic over
);

  localparam int CNT_W = $clog2(MAX_ITER + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != CNT_W'(MAX_ITER))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // count value is the number of compare reads already finished
  assign last = (cnt_q == CNT_W'(MAX_ITER - 1));
  assign over = ({1'b0, cnt_q} >= (CNT_W + 1)'(WARN_ITER));

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_ITER)); // R6

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
  import poll_pkg::*;
#(
  parameter int              ADDR_W       = 24,
  parameter int              CLK_KHZ      = 100000,
  parameter int              SLOW_WAIT_US = 8000,
  parameter int              MAX_ITER     = 32'h0FFFFFFF,
  parameter int              WARN_ITER    = 32'h00100000,
  parameter logic [ADDR_W-1:0] DEV_BASE   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [7:0]        expect_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_req,
  input  logic [7:0]        rd_data,
  input  logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              long_warn
);

  localparam int WAIT_CYC = (CLK_KHZ * SLOW_WAIT_US) / 1000;

  poll_state_e       state_q;
  poll_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        exp_q;
  logic [7:0]        prev_q;

  logic              rp_go;
  logic [ADDR_W-1:0] rp_addr;
  logic [7:0]        rp_byte;
  logic              rp_got;
  logic              tm_arm;
  logic              tm_fin;
  logic              cnt_clr;
  logic              cnt_inc;
  logic              cnt_last;
  logic              cnt_over;
  logic              slow;
  logic              hit;
  logic              accept;

  assign slow    = (mode_q == PM_TOGGLE_SLOW);
  assign rp_addr = slow ? DEV_BASE : addr_q;
  assign rp_go   = (state_q == ST_REF_ISSUE) || (state_q == ST_CMP_ISSUE);
  assign accept  = (state_q == ST_IDLE) && start;

  always_comb begin
    if (is_toggle(mode_q)) hit = ((rp_byte ^ prev_q) & TOGGLE_MASK) == 8'h00;
    else                   hit = ((rp_byte ^ exp_q) & DATA_MASK) == 8'h00;
  end

  assign cnt_clr = accept;
  assign cnt_inc = (state_q == ST_CMP_WAIT) && rp_got;
  assign tm_arm  = slow && rp_got &&
                   ((state_q == ST_REF_WAIT) ||
                    ((state_q == ST_CMP_WAIT) && !hit && !cnt_last));

  poll_read_port #(.ADDR_W(ADDR_W), .DATA_W(8)) u_port (
    .clk      (clk),
    .rst      (rst),
    .go       (rp_go),
    .go_addr  (rp_addr),
    .rd_addr  (rd_addr),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .got_data (rp_byte),
    .got      (rp_got)
  );

  poll_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk (clk),
    .rst (rst),
    .arm (tm_arm),
    .fin (tm_fin)
  );

  poll_iter_counter #(.MAX_ITER(MAX_ITER), .WARN_ITER(WARN_ITER)) u_count (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .last (cnt_last),
    .over (cnt_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= PM_TOGGLE;
      addr_q    <= '0;
      exp_q     <= '0;
      prev_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      long_warn <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= poll_mode_e'(mode);
            addr_q    <= poll_addr;
            exp_q     <= expect_data;
            long_warn <= 1'b0;
            busy      <= 1'b1;
            state_q   <= is_toggle(poll_mode_e'(mode)) ? ST_REF_ISSUE : ST_CMP_ISSUE;
          end
        end
        ST_REF_ISSUE: state_q <= ST_REF_WAIT;
        ST_REF_WAIT: begin
          if (rp_got) begin
            prev_q  <= rp_byte;
            state_q <= slow ? ST_DELAY : ST_CMP_ISSUE;
          end
        end
        ST_DELAY: begin
          if (tm_fin) state_q <= ST_CMP_ISSUE;
        end
        ST_CMP_ISSUE: state_q <= ST_CMP_WAIT;
        ST_CMP_WAIT: begin
          if (rp_got) begin
            prev_q <= rp_byte;
            if (hit || cnt_last) begin
              done      <= hit;
              timeout   <= !hit;
              long_warn <= cnt_over;
              busy      <= 1'b0;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= slow ? ST_DELAY : ST_CMP_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout); // R9

  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout)); // R9

  AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done || timeout) |-> !busy); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(addr_q) && $stable(mode_q) && $stable(exp_q))); // R2

  AST_SLOW_BASE: assert property (@(posedge clk) disable iff (rst)
    (rd_req && busy && slow) |-> (rd_addr == DEV_BASE)); // R8

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy); // R3

endmodule

// File: tb/test_flash_ready_poller.sv
module test_flash_ready_poller;

  localparam int              ADDR_W = 20;
  localparam int              CLK_KHZ = 1000;
  localparam int              SLOW_US = 6;
  localparam int              MAXI = 40;
  localparam int              WARNI = 20;
  localparam int              WAITC = (CLK_KHZ * SLOW_US) / 1000;
  localparam logic [ADDR_W-1:0] BASE = 20'h3F000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [ADDR_W-1:0] poll_addr = '0;
  logic [7:0]        expect_data = '0;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_req;
  logic [7:0]        rd_data = '0;
  logic              rd_valid = 1'b0;
  logic              busy, done, timeout, long_warn;

  always #5 clk = ~clk;

  flash_ready_poller #(
    .ADDR_W(ADDR_W), .CLK_KHZ(CLK_KHZ), .SLOW_WAIT_US(SLOW_US),
    .MAX_ITER(MAXI), .WARN_ITER(WARNI), .DEV_BASE(BASE)
  ) i_flash_ready_poller (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .poll_addr(poll_addr),
    .expect_data(expect_data), .rd_addr(rd_addr), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .timeout(timeout), .long_warn(long_warn)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // device model state
  int              m_b = 0;
  logic [1:0]      m_mode = 2'b00;
  logic [7:0]      m_exp = '0;
  logic [ADDR_W-1:0] m_addr = '0;
  int              reads = 0;
  int              addr_err = 0;
  int              gap = 0;
  int              min_gap = 0;
  int              max_gap = 0;
  int              n_gaps = 0;
  bit              waiting = 0;
  int              lat_left = 0;

  function automatic logic [7:0] model_byte(input int k);
    logic [7:0] v;
    int kk;
    v = 8'($urandom);
    if (m_mode[1] == 1'b0) begin
      kk = (k < m_b) ? k : m_b;
      v[6] = kk[0];
    end else begin
      v[7] = (k < m_b) ? ~m_exp[7] : m_exp[7];
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !rd_req) gap = gap + 1;
      if (rd_valid) begin
        rd_valid = 1'b0;
        reads = reads + 1;
      end else if (rd_req) begin
        if (gap > 0) begin
          if (reads >= 1) begin
            if (n_gaps == 0 || gap < min_gap) min_gap = gap;
            if (n_gaps == 0 || gap > max_gap) max_gap = gap;
            n_gaps = n_gaps + 1;
          end
          gap = 0;
        end
        if (!waiting) begin
          waiting = 1;
          lat_left = int'($urandom % 4);
        end
        if (lat_left == 0) begin
          rd_valid = 1'b1;
          rd_data = model_byte(reads);
          waiting = 0;
          if (rd_addr != m_addr) addr_err = addr_err + 1;
        end else begin
          lat_left = lat_left - 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_poll(input logic [1:0] md, input logic [ADDR_W-1:0] ad,
                          input logic [7:0] ex, input int b, input bit inject);
    int  c;
    bit  exp_to;
    bit  exp_warn;
    int  exp_reads;
    int  w;
    bit  got_done;
    bit  got_to;
    bit  ended;
    exp_to    = (b + 1) > MAXI;
    c         = exp_to ? MAXI : b + 1;
    exp_warn  = c > WARNI;
    exp_reads = (md[1] == 1'b0) ? c + 1 : c;
    @(negedge clk);
    m_b = b; m_mode = md; m_exp = ex;
    m_addr = (md == 2'b01) ? BASE : ad;
    reads = 0; addr_err = 0; gap = 0; n_gaps = 0; min_gap = 0; max_gap = 0;
    start = 1'b1; mode = md; poll_addr = ad; expect_data = ex;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && long_warn == 1'b0, "R2", "busy after start", int'(busy), 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      start = 1'b1; mode = ~md; poll_addr = ~ad; expect_data = ~ex;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0; ended = 0; got_done = 0; got_to = 0;
    while (!ended && w < 5000) begin
      if (done || timeout) begin
        ended = 1; got_done = done; got_to = timeout;
      end else begin
        @(negedge clk);
        w++;
      end
    end
    check(ended, "R6", "poll ended", int'(ended), 1);
    check(got_done == !exp_to, "R4", "done outcome", int'(got_done), int'(!exp_to));
    check(got_to == exp_to, "R6", "timeout outcome", int'(got_to), int'(exp_to));
    check(!busy, "R9", "busy low with end pulse", int'(busy), 0);
    check(long_warn == exp_warn, "R7", "warn flag", int'(long_warn), int'(exp_warn));
    @(negedge clk);
    check(!done && !timeout, "R9", "end pulse single cycle", int'(done | timeout), 0);
    check(reads == exp_reads, (md[1] ? "R5" : "R4"), "read count", reads, exp_reads);
    check(addr_err == 0, (md == 2'b01 ? "R8" : "R3"), "read address", addr_err, 0);
    if (n_gaps > 0) begin
      if (md == 2'b01) check(min_gap >= WAITC, "R8", "slow gap", min_gap, WAITC);
      else             check(max_gap < WAITC, "R8", "fast gap", max_gap, WAITC - 1);
    end
    repeat (3) @(negedge clk);
    check(long_warn == exp_warn, "R7", "warn held", int'(long_warn), int'(exp_warn));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !timeout && !long_warn && !rd_req, "R1", "reset state",
          int'({busy, done, timeout, long_warn, rd_req}), 0);
    // R4 toggle directed
    run_poll(2'b00, 20'h01234, 8'h00, 0, 0);
    run_poll(2'b00, 20'h01235, 8'h00, WARNI - 1, 0);
    run_poll(2'b00, 20'h01236, 8'h00, WARNI, 0);
    run_poll(2'b00, 20'h01237, 8'h00, MAXI - 1, 0);
    run_poll(2'b00, 20'h01238, 8'h00, MAXI, 0);
    run_poll(2'b00, 20'h01239, 8'h00, MAXI + 20, 0);
    // R5 data directed
    run_poll(2'b10, 20'h0AAAA, 8'h80, 0, 0);
    run_poll(2'b11, 20'h0AAAB, 8'h00, MAXI - 1, 0);
    run_poll(2'b10, 20'h0AAAC, 8'h7F, MAXI, 0);
    // R8 slow toggle
    run_poll(2'b01, 20'h05555, 8'h00, 3, 0);
    run_poll(2'b01, 20'h05556, 8'h00, 0, 0);
    // R2 start while busy is ignored
    run_poll(2'b00, 20'h02222, 8'h00, 10, 1);
    run_poll(2'b10, 20'h02223, 8'hC3, 8, 1);
    // random polls
    for (int i = 0; i < 16; i++) begin
      run_poll(2'($urandom % 4), ADDR_W'($urandom), 8'($urandom),
               int'($urandom % 46), 1'($urandom % 2));
    end
    finish_run();
  end

endmodule